// File: doc/BRIEF.md
# Arithmetic and Shift Unit with Condition Flags

This block computes a 32-bit result from two operands and derives the four condition flags: negative, zero, carry and overflow. It performs four operations: add, subtract, arithmetic shift right and move. A small register inside the block holds the current flags. The flag logic reads them back so that operations which leave a flag alone can pass its old value through. The register loads the new flags on every clock edge, but the new flags equal the held ones unless the update enable is set.

Subtract runs through the same adder as add, with the second operand inverted and a carry-in of one. An input selects how the carry flag is stored after a subtract. It can keep the raw adder carry, so that carry means no borrow. It can also store the inverse of that carry, so that carry means a borrow occurred. Only add and subtract change the overflow flag. A shift moves the last bit shifted out into the carry flag. A move only refreshes the negative and zero flags.

Top module: `alu_flags_unit`

## Requirements
- R1: With op_sel = 2'b00 (add), result equals op_a + op_b modulo 2^32. With flag_we set, the carry flag is the carry out of bit 31.
- R2: With op_sel = 2'b01 (subtract) and borrow_mode = 0, result equals op_a - op_b. The carry flag is the raw carry out of op_a + ~op_b + 1.
- R3: With op_sel = 2'b01 and borrow_mode = 1, the result is unchanged from R2. The stored carry flag is the inverse of that adder carry out.
- R4: For add and subtract with flag_we set, the overflow flag is the XOR of the carry into bit 31 and the carry out of bit 31. Example: 0x80000000 - 1 with borrow_mode = 0 gives flags 0011.
- R5: With flag_we set, the negative flag equals result[31] and the zero flag is set exactly when result is zero, for every operation.
- R6: With op_sel = 2'b10 (arithmetic shift right), result is op_a shifted right by op_b[4:0] with sign fill. For a nonzero amount, the carry flag takes op_a[amount-1]. The overflow flag keeps its held value.
- R7: An arithmetic shift by an amount of zero returns op_a and leaves the carry flag at its held value.
- R8: With op_sel = 2'b11 (move), result equals op_b. The carry and overflow flags keep their held values.
- R9: With flag_we low, flags_next equals flags_q, while result is still produced as for the selected operation.
- R10: flags_q loads flags_next on each rising clock edge. A synchronous active-low reset clears flags_q to 0000. Flag vectors are packed as {N, Z, C, V} from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| op_a | input | 32 | First operand; the value shifted by an arithmetic shift |
| op_b | input | 32 | Second operand; bits 4:0 give the shift amount |
| op_sel | input | 2 | 00 add, 01 subtract, 10 arithmetic shift right, 11 move |
| flag_we | input | 1 | Allows the operation to change the flags |
| borrow_mode | input | 1 | 1: subtract stores carry as a borrow |
| result | output | 32 | Combinational result |
| flags_next | output | 4 | Flags that the next edge will load, {N,Z,C,V} |
| flags_q | output | 4 | Held flags, {N,Z,C,V} |

## Verification
A wrong held flag is visible on flags_q one edge after the operation that produced it. It also appears at once on flags_next for any later operation that passes that flag through. For example, a shift exposes a stale overflow flag, and a move exposes stale carry and overflow flags. A wrong carry-into-MSB term corrupts overflow only when the operand sign bits agree in the adder. For that reason the bench uses sign-boundary pairs in both carry conventions. An error in the shifter's last-bit selection appears on the carry flag in the same cycle, and only for nonzero amounts.

// File: rtl/alu_flags_pkg.sv
// Package: shared operation codes and the flag record for the ALU.
// Assumes the flag record is packed as {neg, zero, carry, ovf}, MSB first.
package alu_flags_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_ASR = 2'b10,
        OP_MOV = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } nzcv_t;
endpackage

// File: rtl/alu_adder.sv
// Module: two-operand adder that also subtracts (a + ~b + 1).
// Exposes the carry into the top bit and the carry out of it, so that
// signed overflow can be derived from them. Assumes W >= 2.
module alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry_msb_in,
    output logic         carry_out
);
    logic [W-1:0] b_eff;
    logic [W-1:0] low_sum;
    logic         msb_bit;

    // Purpose: invert the second operand for subtract and add the lower bits.
    always_comb begin
        b_eff        = sub ? ~b : b;
        low_sum      = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, sub};
        carry_msb_in = low_sum[W-1];
        msb_bit      = a[W-1] ^ b_eff[W-1] ^ carry_msb_in;
        carry_out    = (a[W-1] & b_eff[W-1]) | (carry_msb_in & (a[W-1] ^ b_eff[W-1]));
        sum          = {msb_bit, low_sum[W-2:0]};
    end
endmodule

// File: rtl/alu_shifter.sv
// Module: arithmetic right shift with the last bit shifted out.
// Assumes amounts range from 0 to W-1. The last-out bit is only
// meaningful when the amount is nonzero; amt_zero tells the caller.
module alu_shifter #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   res,
    output logic           last_out,
    output logic           amt_zero
);
    logic [W:0] ext_shift;

    // Purpose: sign-fill shift and pick the bit just below the new LSB.
    always_comb begin
        res       = W'($signed(a) >>> amt);
        ext_shift = {a, 1'b0} >> amt;
        last_out  = ext_shift[0];
        amt_zero  = (amt == '0);
    end
endmodule

// File: rtl/alu_flag_logic.sv
// Module: picks the result for the operation and builds the next flags.
// Assumes cur holds the registered flags. When upd is low every flag
// passes through, while the result is still produced.
module alu_flag_logic
    import alu_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic         upd,
    input  logic         borrow_mode,
    input  logic [W-1:0] mov_val,
    input  logic [W-1:0] add_sum,
    input  logic         add_cin_msb,
    input  logic         add_cout,
    input  logic [W-1:0] shf_res,
    input  logic         shf_last,
    input  logic         shf_zero,
    input  nzcv_t        cur,
    output logic [W-1:0] res,
    output nzcv_t        nxt
);
    nzcv_t calc;

    // Purpose: select the result and the per-operation carry and overflow.
    always_comb begin
        calc = cur;
        unique case (op)
            OP_ADD: begin
                res        = add_sum;
                calc.carry = add_cout;
                calc.ovf   = add_cin_msb ^ add_cout;
            end
            OP_SUB: begin
                res        = add_sum;
                calc.carry = borrow_mode ? ~add_cout : add_cout;
                calc.ovf   = add_cin_msb ^ add_cout;
            end
            OP_ASR: begin
                res        = shf_res;
                calc.carry = shf_zero ? cur.carry : shf_last;
            end
            default: begin
                res = mov_val;
            end
        endcase
        calc.neg  = res[W-1];
        calc.zero = (res == '0);
    end

    // Purpose: hold all flags when the update enable is low.
    always_comb begin
        nxt = upd ? calc : cur;
    end
endmodule

// File: rtl/alu_flag_reg.sv
// Module: holding register for the condition flags.
// Assumes a synchronous active-low reset that clears every flag.
module alu_flag_reg
    import alu_flags_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  nzcv_t d,
    output nzcv_t q
);
    // Purpose: load the next flags each edge, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/alu_flags_unit.sv
// Module: top of the arithmetic and shift unit with condition flags.
// Assumes op_b's low bits give the shift amount. The flags go out
// packed as {N, Z, C, V}.
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   op_sel,
    input  logic         flag_we,
    input  logic         borrow_mode,
    output logic [W-1:0] result,
    output logic [3:0]   flags_next,
    output logic [3:0]   flags_q
);
    logic [W-1:0] add_sum;
    logic         add_cin_msb;
    logic         add_cout;
    logic [W-1:0] shf_res;
    logic         shf_last;
    logic         shf_zero;
    nzcv_t        cur_flags;
    nzcv_t        nxt_flags;
    alu_op_e      op;

    assign op         = alu_op_e'(op_sel);
    assign flags_next = nxt_flags;
    assign flags_q    = cur_flags;

    alu_adder #(.W(W)) u_adder (
        .a            (op_a),
        .b            (op_b),
        .sub          (op == OP_SUB),
        .sum          (add_sum),
        .carry_msb_in (add_cin_msb),
        .carry_out    (add_cout)
    );

    alu_shifter #(.W(W), .SHW(SHW)) u_shifter (
        .a        (op_a),
        .amt      (op_b[SHW-1:0]),
        .res      (shf_res),
        .last_out (shf_last),
        .amt_zero (shf_zero)
    );

    alu_flag_logic #(.W(W)) u_flags (
        .op          (op),
        .upd         (flag_we),
        .borrow_mode (borrow_mode),
        .mov_val     (op_b),
        .add_sum     (add_sum),
        .add_cin_msb (add_cin_msb),
        .add_cout    (add_cout),
        .shf_res     (shf_res),
        .shf_last    (shf_last),
        .shf_zero    (shf_zero),
        .cur         (cur_flags),
        .res         (result),
        .nxt         (nxt_flags)
    );

    alu_flag_reg u_freg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt_flags),
        .q     (cur_flags)
    );
endmodule

// File: rtl/alu_flags_checker.sv
// Module: property checker attached to the unit's top through bind.
// Assumes flag vectors packed as {N, Z, C, V}.
module alu_flags_checker #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [1:0]   op_sel,
    input logic         flag_we,
    input logic [W-1:0] result,
    input logic [3:0]   flags_next,
    input logic [3:0]   flags_q
);
    assert_hold_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |-> flags_next == flags_q);

    assert_register_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> flags_q == $past(flags_next));

    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> flags_q == 4'b0000);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[1] |-> flags_next[0] == flags_q[0]);

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> flags_next[2] == (result == '0));

    assert_neg_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> flags_next[3] == result[W-1]);

    assert_shift_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 2'b10 && op_b[SHW-1:0] != '0)
            |-> flags_next[1] == op_a[op_b[SHW-1:0] - 1'b1]);

    assert_shift_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b10 && op_b[SHW-1:0] == '0)
            |-> (result == op_a && flags_next[1] == flags_q[1]));

    assert_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 2'b11 |-> (result == op_b && flags_next[1] == flags_q[1]));
endmodule

bind alu_flags_unit alu_flags_checker #(.W(W), .SHW(SHW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_a       (op_a),
    .op_b       (op_b),
    .op_sel     (op_sel),
    .flag_we    (flag_we),
    .result     (result),
    .flags_next (flags_next),
    .flags_q    (flags_q)
);

// File: tb/alu_flags_unit_bench.sv
module alu_flags_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  op_sel = '0;
    logic        flag_we = 1'b0;
    logic        borrow_mode = 1'b0;
    logic [31:0] result;
    logic [3:0]  flags_next;
    logic [3:0]  flags_q;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [3:0] model_q = 4'b0000;

    typedef struct {
        string       req;
        logic [31:0] res;
        logic [3:0]  nxt;
        logic [3:0]  cur;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    alu_flags_unit u_alu_flags_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .flag_we(flag_we), .borrow_mode(borrow_mode), .result(result),
        .flags_next(flags_next), .flags_q(flags_q)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Independent reference: 33-bit sum, sign-based overflow.
    task automatic model(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] op, input logic we, input logic bm,
                         input logic [3:0] cur,
                         output logic [31:0] r, output logic [3:0] f);
        logic [32:0] wide;
        logic c, v;
        int amt;
        c = cur[1];
        v = cur[0];
        amt = int'(b[4:0]);
        case (op)
            2'b00: begin
                wide = {1'b0, a} + {1'b0, b};
                r = wide[31:0]; c = wide[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            2'b01: begin
                wide = {1'b0, a} + {1'b0, ~b} + 33'd1;
                r = wide[31:0]; c = bm ? ~wide[32] : wide[32];
                v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            2'b10: begin
                r = $signed(a) >>> amt;
                if (amt != 0) c = a[amt-1];
            end
            default: r = b;
        endcase
        f = we ? {r[31], r == 32'd0, c, v} : cur;
    endtask

    // Driver: applies one operation and pushes the expectation.
    task automatic do_op(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] op, input logic we, input logic bm);
        exp_t e;
        @(negedge clk);
        op_a = a; op_b = b; op_sel = op; flag_we = we; borrow_mode = bm;
        e.req = req;
        e.cur = model_q;
        model(a, b, op, we, bm, model_q, e.res, e.nxt);
        model_q = e.nxt;
        sb.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_q = 4'b0000;
        #2;
        check("R10", "flags after reset", {28'd0, flags_q}, 32'd0);
    endtask

    // Monitor: pops one expectation per cycle and compares all outputs.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "result", result, e.res);
                check(e.req, "flags_next", {28'd0, flags_next}, {28'd0, e.nxt});
                check(e.req, "flags_q", {28'd0, flags_q}, {28'd0, e.cur});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        do_op("R1",  32'd3, 32'd4, 2'b00, 1'b1, 1'b0);
        do_op("R4",  32'h8000_0000, 32'h8000_0000, 2'b00, 1'b1, 1'b0);
        do_op("R1",  32'hFFFF_FFFF, 32'd1, 2'b00, 1'b1, 1'b0);
        do_op("R2",  32'h8000_0000, 32'd1, 2'b01, 1'b1, 1'b0);
        do_op("R2",  32'd5, 32'd5, 2'b01, 1'b1, 1'b0);
        do_op("R3",  32'd5, 32'd5, 2'b01, 1'b1, 1'b1);
        do_op("R3",  32'd3, 32'd5, 2'b01, 1'b1, 1'b1);
        do_op("R3",  32'h8100_0000, 32'h7F00_0000, 2'b01, 1'b1, 1'b1);
        do_op("R6",  32'h8000_0003, 32'd1, 2'b10, 1'b1, 1'b0);
        do_op("R6",  32'h4000_0000, 32'd31, 2'b10, 1'b1, 1'b0);
        do_op("R6",  32'h0000_0010, 32'd4, 2'b10, 1'b1, 1'b0);
        do_op("R7",  32'h1234_5678, 32'd0, 2'b10, 1'b1, 1'b0);
        do_op("R8",  32'h0, 32'h0, 2'b11, 1'b1, 1'b0);
        do_op("R8",  32'h0, 32'hF000_0000, 2'b11, 1'b1, 1'b0);
        do_op("R5",  32'h7FFF_FFFF, 32'd1, 2'b00, 1'b1, 1'b0);
        do_op("R9",  32'hFFFF_FFFF, 32'd1, 2'b00, 1'b0, 1'b0);
        do_op("R9",  32'h8000_0000, 32'd1, 2'b01, 1'b0, 1'b1);
        do_op("R10", 32'd1, 32'd1, 2'b01, 1'b1, 1'b0);
        do_op("R10", 32'd0, 32'd0, 2'b11, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // Fixed-value checks for the two signature overflow cases.
        op_a = 32'h8000_0000; op_b = 32'd1; op_sel = 2'b01; flag_we = 1'b1; borrow_mode = 1'b0;
        #2;
        check("R4", "0x80000000-1 flags", {28'd0, flags_next}, 32'h3);
        op_a = 32'h8100_0000; op_b = 32'h7F00_0000; borrow_mode = 1'b1;
        #2;
        check("R3", "borrow-mode overflow only", {28'd0, flags_next}, 32'h1);
        @(negedge clk);
        op_sel = 2'b11; flag_we = 1'b0;
        model_q = 4'b0001;
        do_reset();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule